// File: doc/BRIEF.md
# Serial Port Control and Error Status Register

This block holds the software-visible configuration of a serial port and gathers the error events reported by its receive and transmit datapaths. The port works either as an asynchronous UART or as a clocked synchronous I/O link. Software chooses four settings through a simple byte-wide register bus:

- whether parity is used,
- whether parity is odd or even,
- which clock edge moves data,
- whether the I/O clock comes from the internal baud generator or from the external clock pin.

These settings drive the control outputs toward the datapath.

Three sticky error flags report overrun, framing, and one shared bit that means parity error in UART mode and transmit underrun in clocked I/O mode. A register read returns the flags as they were before that read. The flags then clear on the clock edge that ends the read. An error event that arrives in the same cycle as a clearing read is kept.

Top module: `sio_ctl_stat`

## Requirements
- R1: After reset, bits 6 to 0 of the read data are 0 and all four control outputs are 0.
- R2: A write (bus_sel=1, bus_wr=1) stores wdata bit 6 (even parity), bit 5 (parity enable), bit 1 (falling edge) and bit 0 (external clock). These drive par_even_o, par_en_o, edge_fall_o and clk_src_ext_o, and read back at the same bit positions, from the cycle after the write. Without a write they hold.
- R3: Write data in bits 7, 4, 3 and 2 is ignored. A write neither sets nor clears any error flag.
- R4: Read data bit 7 always equals rx_bit8.
- R5: The overrun flag (bit 4) sets in either mode when rx_frame_done is high while rx_buf_full is high.
- R6: In UART mode (uart_mode=1), the parity/underrun flag (bit 3) sets on rx_par_err.
- R7: In I/O mode (uart_mode=0), bit 3 sets only when dbl_buf_en, sclk_is_input, tx_shift_done and tx_buf_empty are all high. rx_par_err has no effect in this mode.
- R8: The framing flag (bit 2) sets on rx_frm_err only in UART mode. It never sets in I/O mode.
- R9: A read (bus_sel=1, bus_wr=0) returns the flag values held before the read. All three flags are 0 from the next cycle.
- R10: When a set event and a clearing read fall in the same cycle, that flag is 1 after the cycle.
- R11: A flag that is set stays set until a read clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; release is synchronized inside the block |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read (clears flags) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from the stored state |
| uart_mode | input | 1 | 1 = UART, 0 = clocked I/O |
| dbl_buf_en | input | 1 | Transmit double-buffering enabled |
| sclk_is_input | input | 1 | Serial clock is driven from outside |
| rx_frame_done | input | 1 | Strobe: a complete frame was received |
| rx_buf_full | input | 1 | Receive buffer still holds unread data |
| rx_bit8 | input | 1 | Ninth received data bit |
| rx_par_err | input | 1 | Strobe: parity mismatch on a received frame |
| rx_frm_err | input | 1 | Strobe: stop bit missing |
| tx_shift_done | input | 1 | Strobe: transmit shifter finished a word |
| tx_buf_empty | input | 1 | Transmit double-buffer holds no new word |
| par_en_o | output | 1 | Parity enable to datapath |
| par_even_o | output | 1 | 1 = even parity, 0 = odd |
| edge_fall_o | output | 1 | 1 = data on falling edge, 0 = rising edge |
| clk_src_ext_o | output | 1 | 1 = external clock pin, 0 = baud generator |

## Verification
A write, an error event and a clearing read all act on one clock edge. Their effects are therefore due on the read data and control outputs one cycle after the stimulus. Bit 7 and the pre-clear flag value are due in the same cycle as the input or read strobe that produces them. The bench drives inputs at the falling edge and updates its expected state at the rising edge. It compares at the next falling edge. For a same-cycle result it also looks at the outputs a moment after driving, before the rising edge.

// File: rtl/sio_csr_pkg.sv
package sio_csr_pkg;
  localparam int DW    = 8;
  localparam int NFLAG = 3;

  // bit positions in the register word (the datapath side decodes these)
  localparam int B_RB8  = 7;
  localparam int B_EVEN = 6;
  localparam int B_PEN  = 5;
  localparam int B_OVR  = 4;
  localparam int B_PUE  = 3;
  localparam int B_FRM  = 2;
  localparam int B_EDGE = 1;
  localparam int B_SRC  = 0;

  // flag index i lives at register bit B_FRM + i
  localparam int F_FRM = 0;
  localparam int F_PUE = 1;
  localparam int F_OVR = 2;

  typedef struct packed {
    logic even;
    logic pen;
    logic edge_fall;
    logic ext_clk;
  } cfg_t;
endpackage

// File: rtl/sio_rst_sync.sv
module sio_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb sync_d = {sync_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign srst_n = sync_q[STAGES-1];
endmodule

// File: rtl/sio_cfg_reg.sv
module sio_cfg_reg
  import sio_csr_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic wr_en,
  input  cfg_t wr_cfg,
  output cfg_t cfg_q
);
  cfg_t cfg_d;

  always_comb begin
    cfg_d = cfg_q;
    if (wr_en) cfg_d = wr_cfg;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= '0;
    else        cfg_q <= cfg_d;
  end
endmodule

// File: rtl/sio_err_decode.sv
module sio_err_decode
  import sio_csr_pkg::*;
(
  input  logic             uart_mode,
  input  logic             dbl_buf_en,
  input  logic             sclk_is_input,
  input  logic             rx_frame_done,
  input  logic             rx_buf_full,
  input  logic             rx_par_err,
  input  logic             rx_frm_err,
  input  logic             tx_shift_done,
  input  logic             tx_buf_empty,
  output logic [NFLAG-1:0] set_o
);
  logic underrun;

  always_comb begin
    underrun      = dbl_buf_en & sclk_is_input & tx_shift_done & tx_buf_empty;
    set_o         = '0;
    set_o[F_OVR]  = rx_frame_done & rx_buf_full;
    set_o[F_PUE]  = uart_mode ? rx_par_err : underrun;
    set_o[F_FRM]  = uart_mode & rx_frm_err;
  end
endmodule

// File: rtl/sio_flag_cell.sv
module sio_flag_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  logic q_d;

  // a new event outranks the clearing read
  always_comb q_d = set_i | (q_o & ~clr_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_o <= 1'b0;
    else        q_o <= q_d;
  end
endmodule

// File: rtl/sio_ctl_stat.sv
module sio_ctl_stat
  import sio_csr_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_sel,
  input  logic          bus_wr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic          uart_mode,
  input  logic          dbl_buf_en,
  input  logic          sclk_is_input,
  input  logic          rx_frame_done,
  input  logic          rx_buf_full,
  input  logic          rx_bit8,
  input  logic          rx_par_err,
  input  logic          rx_frm_err,
  input  logic          tx_shift_done,
  input  logic          tx_buf_empty,
  output logic          par_en_o,
  output logic          par_even_o,
  output logic          edge_fall_o,
  output logic          clk_src_ext_o
);
  logic             srst_n;
  logic             wr_en;
  logic             rd_clr;
  cfg_t             wr_cfg;
  cfg_t             cfg_q;
  logic [NFLAG-1:0] flag_set;
  logic [NFLAG-1:0] flag_q;
  logic             unused_wbits;

  sio_rst_sync #(.STAGES(2)) rst_sync_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .srst_n (srst_n)
  );

  always_comb begin
    wr_en            = bus_sel & bus_wr;
    rd_clr           = bus_sel & ~bus_wr;
    wr_cfg.even      = bus_wdata[B_EVEN];
    wr_cfg.pen       = bus_wdata[B_PEN];
    wr_cfg.edge_fall = bus_wdata[B_EDGE];
    wr_cfg.ext_clk   = bus_wdata[B_SRC];
  end

  assign unused_wbits = ^{bus_wdata[B_RB8], bus_wdata[B_OVR:B_FRM]};

  sio_cfg_reg cfg_i (
    .clk    (clk),
    .rst_n  (srst_n),
    .wr_en  (wr_en),
    .wr_cfg (wr_cfg),
    .cfg_q  (cfg_q)
  );

  sio_err_decode dec_i (
    .uart_mode     (uart_mode),
    .dbl_buf_en    (dbl_buf_en),
    .sclk_is_input (sclk_is_input),
    .rx_frame_done (rx_frame_done),
    .rx_buf_full   (rx_buf_full),
    .rx_par_err    (rx_par_err),
    .rx_frm_err    (rx_frm_err),
    .tx_shift_done (tx_shift_done),
    .tx_buf_empty  (tx_buf_empty),
    .set_o         (flag_set)
  );

  for (genvar g = 0; g < NFLAG; g++) begin : g_flag
    sio_flag_cell cell_i (
      .clk   (clk),
      .rst_n (srst_n),
      .set_i (flag_set[g]),
      .clr_i (rd_clr),
      .q_o   (flag_q[g])
    );
  end

  always_comb begin
    bus_rdata         = '0;
    bus_rdata[B_RB8]  = rx_bit8;
    bus_rdata[B_EVEN] = cfg_q.even;
    bus_rdata[B_PEN]  = cfg_q.pen;
    bus_rdata[B_EDGE] = cfg_q.edge_fall;
    bus_rdata[B_SRC]  = cfg_q.ext_clk;
    for (int i = 0; i < NFLAG; i++) bus_rdata[B_FRM+i] = flag_q[i];
  end

  assign par_en_o      = cfg_q.pen;
  assign par_even_o    = cfg_q.even;
  assign edge_fall_o   = cfg_q.edge_fall;
  assign clk_src_ext_o = cfg_q.ext_clk;
endmodule

// File: rtl/sio_ctl_stat_chk.sv
module sio_ctl_stat_chk (
  input logic       clk,
  input logic       srst_n,
  input logic       bus_sel,
  input logic       bus_wr,
  input logic [7:0] bus_wdata,
  input logic [7:0] bus_rdata,
  input logic       uart_mode,
  input logic       dbl_buf_en,
  input logic       sclk_is_input,
  input logic       rx_frame_done,
  input logic       rx_buf_full,
  input logic       tx_shift_done,
  input logic       tx_buf_empty,
  input logic       par_en_o,
  input logic       par_even_o,
  input logic       edge_fall_o,
  input logic       clk_src_ext_o
);
  p_cfg_write_r2: assert property (@(posedge clk) disable iff (!srst_n)
    (bus_sel && bus_wr) |=> ({par_even_o, par_en_o, edge_fall_o, clk_src_ext_o} ==
      {$past(bus_wdata[6]), $past(bus_wdata[5]), $past(bus_wdata[1]), $past(bus_wdata[0])}));

  p_cfg_hold_r2: assert property (@(posedge clk) disable iff (!srst_n)
    !(bus_sel && bus_wr) |=> $stable({par_even_o, par_en_o, edge_fall_o, clk_src_ext_o}));

  p_ovr_set_r5: assert property (@(posedge clk) disable iff (!srst_n)
    (rx_frame_done && rx_buf_full) |=> bus_rdata[4]);

  p_und_set_r7: assert property (@(posedge clk) disable iff (!srst_n)
    (!uart_mode && dbl_buf_en && sclk_is_input && tx_shift_done && tx_buf_empty) |=> bus_rdata[3]);

  p_und_block_r7: assert property (@(posedge clk) disable iff (!srst_n)
    (!uart_mode && !(dbl_buf_en && sclk_is_input && tx_shift_done && tx_buf_empty) && !bus_rdata[3])
      |=> !bus_rdata[3]);

  p_frm_io_r8: assert property (@(posedge clk) disable iff (!srst_n)
    (!uart_mode && !bus_rdata[2]) |=> !bus_rdata[2]);

  p_sticky_r11: assert property (@(posedge clk) disable iff (!srst_n)
    !(bus_sel && !bus_wr) |=> (($past(bus_rdata[4:2]) & ~bus_rdata[4:2]) == 3'b000));
endmodule

bind sio_ctl_stat sio_ctl_stat_chk chk_i (
  .clk           (clk),
  .srst_n        (srst_n),
  .bus_sel       (bus_sel),
  .bus_wr        (bus_wr),
  .bus_wdata     (bus_wdata),
  .bus_rdata     (bus_rdata),
  .uart_mode     (uart_mode),
  .dbl_buf_en    (dbl_buf_en),
  .sclk_is_input (sclk_is_input),
  .rx_frame_done (rx_frame_done),
  .rx_buf_full   (rx_buf_full),
  .tx_shift_done (tx_shift_done),
  .tx_buf_empty  (tx_buf_empty),
  .par_en_o      (par_en_o),
  .par_even_o    (par_even_o),
  .edge_fall_o   (edge_fall_o),
  .clk_src_ext_o (clk_src_ext_o)
);

// File: tb/sio_ctl_stat_tb_top.sv
`timescale 1ns/1ps
module sio_ctl_stat_tb_top;
  localparam int HALF = 10;
  localparam int LIMIT = 200000;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       bus_sel, bus_wr;
  logic [7:0] bus_wdata, bus_rdata;
  logic       uart_mode, dbl_buf_en, sclk_is_input;
  logic       rx_frame_done, rx_buf_full, rx_bit8, rx_par_err, rx_frm_err;
  logic       tx_shift_done, tx_buf_empty;
  logic       par_en_o, par_even_o, edge_fall_o, clk_src_ext_o;

  int   nchk = 0;
  int   nerr = 0;
  logic done = 1'b0;
  logic [3:0] exp_cfg;  // {even, pen, edge, src}
  logic [2:0] exp_fl;   // {ovr, pue, frm}

  always #HALF clk = ~clk;

  sio_ctl_stat dut_i (.*);

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [2:0] next_flags(input logic [2:0] fl);
    logic [2:0] s;
    s[2] = rx_frame_done & rx_buf_full;
    s[1] = uart_mode ? rx_par_err : (dbl_buf_en & sclk_is_input & tx_shift_done & tx_buf_empty);
    s[0] = uart_mode & rx_frm_err;
    return s | (fl & ~{3{bus_sel & ~bus_wr}});
  endfunction

  task automatic idle();
    bus_sel = 0; bus_wr = 0; bus_wdata = '0;
    rx_frame_done = 0; rx_buf_full = 0; rx_par_err = 0; rx_frm_err = 0;
    tx_shift_done = 0; tx_buf_empty = 0;
  endtask

  task automatic check_all();
    chk("R4 ninth bit", {7'd0, bus_rdata[7]}, {7'd0, rx_bit8});
    chk("R2 readback", {4'd0, bus_rdata[6:5], bus_rdata[1:0]}, {4'd0, exp_cfg});
    chk("R2 outputs", {4'd0, par_even_o, par_en_o, edge_fall_o, clk_src_ext_o}, {4'd0, exp_cfg});
    chk("R5 overrun", {7'd0, bus_rdata[4]}, {7'd0, exp_fl[2]});
    chk("R6 or R7 parity/underrun", {7'd0, bus_rdata[3]}, {7'd0, exp_fl[1]});
    chk("R8 framing", {7'd0, bus_rdata[2]}, {7'd0, exp_fl[0]});
  endtask

  // one cycle: inputs already driven; model at posedge, compare at negedge
  task automatic tick();
    @(posedge clk);
    exp_fl = next_flags(exp_fl);
    if (bus_sel && bus_wr) exp_cfg = {bus_wdata[6], bus_wdata[5], bus_wdata[1], bus_wdata[0]};
    @(negedge clk);
    check_all();
    idle();
  endtask

  initial begin
    void'($urandom(32'h00C0FFEE));
    rst_n = 0; uart_mode = 1; dbl_buf_en = 0; sclk_is_input = 0; rx_bit8 = 0;
    idle();
    exp_cfg = '0; exp_fl = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    chk("R1 reset bits 6..0", {1'b0, bus_rdata[6:0]}, 8'h00);
    chk("R1 reset outputs", {4'd0, par_even_o, par_en_o, edge_fall_o, clk_src_ext_o}, 8'h00);

    // R2 / R3: write all ones; flags must stay 0
    bus_sel = 1; bus_wr = 1; bus_wdata = 8'hFF; tick();
    chk("R3 write ignores flag bits", {5'd0, bus_rdata[4:2]}, 8'h00);
    chk("R2 write all ones", {4'd0, bus_rdata[6:5], bus_rdata[1:0]}, 8'h0F);
    // set all flags in UART mode
    uart_mode = 1; rx_frame_done = 1; rx_buf_full = 1; rx_par_err = 1; rx_frm_err = 1; tick();
    chk("R5 R6 R8 flags set", {5'd0, bus_rdata[4:2]}, 8'h07);
    // R3/R11: a write of zero does not clear
    bus_sel = 1; bus_wr = 1; bus_wdata = 8'h00; tick();
    chk("R3 write does not clear", {5'd0, bus_rdata[4:2]}, 8'h07);
    repeat (4) tick();
    chk("R11 flags sticky", {5'd0, bus_rdata[4:2]}, 8'h07);
    // R9: read returns pre-clear value, then clears
    bus_sel = 1; bus_wr = 0; #1;
    chk("R9 read shows pre-clear", {5'd0, bus_rdata[4:2]}, 8'h07);
    tick();
    chk("R9 cleared after read", {5'd0, bus_rdata[4:2]}, 8'h00);

    // R7: I/O mode, underrun needs all four conditions
    uart_mode = 0;
    for (int m = 0; m < 15; m++) begin
      dbl_buf_en = m[0]; sclk_is_input = m[1]; tx_shift_done = m[2]; tx_buf_empty = m[3];
      rx_par_err = 1; rx_frm_err = 1;
      tick();
      chk("R7 R8 no set in I/O combo", {6'd0, bus_rdata[3:2]}, 8'h00);
    end
    dbl_buf_en = 1; sclk_is_input = 1; tx_shift_done = 1; tx_buf_empty = 1; tick();
    chk("R7 underrun sets", {6'd0, bus_rdata[3:2]}, 8'h02);
    // R5 in I/O mode, R10 with simultaneous read
    rx_frame_done = 1; rx_buf_full = 1; bus_sel = 1; bus_wr = 0; tick();
    chk("R10 set wins over read", {5'd0, bus_rdata[4:2]}, 8'h04);
    rx_frame_done = 1; rx_buf_full = 0; tick();
    chk("R5 no overrun when buffer read", {5'd0, bus_rdata[4:2]}, 8'h04);
    rx_bit8 = 1; #1;
    chk("R4 ninth bit follows", {7'd0, bus_rdata[7]}, 8'h01);
    bus_sel = 1; bus_wr = 0; tick();

    // random phase
    for (int n = 0; n < 4000; n++) begin
      uart_mode     = 1'($urandom_range(0, 1));
      dbl_buf_en    = 1'($urandom_range(0, 1));
      sclk_is_input = 1'($urandom_range(0, 1));
      rx_bit8       = 1'($urandom_range(0, 1));
      rx_frame_done = ($urandom_range(0, 3) == 0);
      rx_buf_full   = 1'($urandom_range(0, 1));
      rx_par_err    = ($urandom_range(0, 5) == 0);
      rx_frm_err    = ($urandom_range(0, 5) == 0);
      tx_shift_done = ($urandom_range(0, 2) == 0);
      tx_buf_empty  = 1'($urandom_range(0, 1));
      bus_sel       = ($urandom_range(0, 3) == 0);
      bus_wr        = 1'($urandom_range(0, 1));
      bus_wdata     = 8'($urandom);
      tick();
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end

  initial begin
    #(2 * HALF * LIMIT);
    if (!done) begin
      nchk++; nerr++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
      $finish;
    end
  end
endmodule